// File: doc/BRIEF.md
# Card Host Register and Interrupt Frontend

This block is the software-facing register file of a simple SD/MMC-style card host. A 32-bit bus master programs a transfer buffer address, a command argument, block length and count, an interrupt mask and a packed command word. It reads back a status word, a 128-bit response held as four 32-bit words, and a card state word. A write to the command register launches the request. The request goes to a command engine over a valid/ready handshake, and the command word, argument, buffer address and block fields stay on output ports for the engine to use.

The engine answers with a one-cycle end-of-command pulse, with the response bits valid in the same cycle. When the data phase finishes it sends a separate one-cycle end-of-data pulse. The status word records end-of-command, end-of-data, card insertion changes and rejected launches. Each status bit is cleared by writing a one to it. A single level interrupt output is high while any enabled status bit is set. Card signalling, data movement and buffer storage are handled by other blocks.

Top module: `sdhost_reg_front`

## Requirements
- R1: After reset the status word, interrupt mask, command register and response words read zero, and both `irq` and `cmdValid` are low.
- R2: The register offsets are: buffer address at byte offset 0x08, argument at 0x10, interrupt mask at 0x04 (bits 3:0), command at 0x0C (bits 15:0), block length at 0x24 and block count at 0x28. Each of these reads back what was written. Block length and block count each keep only bits 10:0, which hold the value minus one, and their upper bits read zero.
- R3: An accepted write to the command register raises `cmdValid` on the next cycle. `cmdValid` stays high, with `cmdWord` unchanged, until a cycle in which `cmdReady` is high. The ports `cmdWord`, `cmdArg`, `bufAddr`, `blkLen` and `blkCnt` show the stored register values.
- R4: Command bits 9:8 give the response type, which decides what an end-of-command pulse captures from `respIn`. Type 2 captures all four response words: word i at offset 0x14+4*i takes `respIn` bits 32*i+31:32*i. Types 1 and 3 capture word 0 only. Type 0 leaves all four words unchanged.
- R5: An end-of-command pulse sets status bit 0 (status at offset 0x00).
- R6: An end-of-data pulse sets status bit 1 only when command bits 13:12 equal 3 (addressed command with data). For any other command class the pulse is ignored.
- R7: The card-inserted input and the write-protect input each pass through a two-flop synchronizer. The card state word at 0x2C shows inserted in bit 0 and write-protected in bit 1. Either edge of the synchronized inserted signal sets status bit 2. Changes on write-protect set no status bit.
- R8: Writing the status register clears each status bit that is one in the written data. An event arriving in the same cycle as the clear of its bit leaves that bit set.
- R9: `irq` is high exactly while the AND of the status bits and the mask bits is nonzero. Status bits whose mask bit is zero still latch.
- R10: A write to the command register while a command is pending is ignored, and it sets status bit 3. A command is pending from its launch until its end-of-command pulse, including the time it waits for `cmdReady`.
- R11: Reads of unmapped offsets return zero. Writes to the response words, the card state word and unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 6 | Byte offset of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data (combinational, zero when not reading) |
| cmdValid | output | 1 | Request toward the command engine |
| cmdReady | input | 1 | Engine accepts the request |
| cmdWord | output | 16 | Stored command word |
| cmdArg | output | 32 | Stored command argument |
| bufAddr | output | 32 | Stored transfer buffer address |
| blkLen | output | 11 | Block length minus one |
| blkCnt | output | 11 | Block count minus one |
| cmdDone | input | 1 | End-of-command pulse from the engine |
| dataDone | input | 1 | End-of-data pulse from the engine |
| respIn | input | 128 | Response bits, valid with `cmdDone` |
| cardInserted | input | 1 | Asynchronous card present level |
| cardWriteProt | input | 1 | Asynchronous write-protect level |
| irq | output | 1 | Level interrupt |

## Verification
Commands are issued with a short response, a long response and no response. This shows whether the response type field selects one, four or none of the response words, and whether long responses land in the correct word order. The same commands are followed by end-of-data pulses under the data class and a non-data class, which shows whether the class field gates the data event. A second launch while the engine withholds ready shows whether an in-flight command is protected. A clear that coincides with an end-of-command pulse shows the priority between setting and clearing a status bit. Rising and falling card-inserted edges are tested apart from write-protect toggles, which shows whether only insertion changes raise an event.

// File: rtl/sdhost_pkg.sv
package sdhost_pkg;

  localparam int STAT_W = 4;
  localparam int RESP_WORDS = 4;

  // status bit positions
  localparam int ST_CMD_END  = 0;
  localparam int ST_DATA_END = 1;
  localparam int ST_CARD_CHG = 2;
  localparam int ST_CMD_ERR  = 3;

  // register byte offsets
  localparam int OFF_STATUS = 'h00;
  localparam int OFF_INTEN  = 'h04;
  localparam int OFF_BUF    = 'h08;
  localparam int OFF_CMD    = 'h0C;
  localparam int OFF_ARG    = 'h10;
  localparam int OFF_RESP0  = 'h14;
  localparam int OFF_BLKLEN = 'h24;
  localparam int OFF_BLKCNT = 'h28;
  localparam int OFF_CARD   = 'h2C;

  typedef enum logic [1:0] {
    RESP_NONE  = 2'd0,
    RESP_SHORT = 2'd1,
    RESP_LONG  = 2'd2,
    RESP_OCR   = 2'd3
  } respKind_t;

  localparam logic [1:0] CLASS_WITH_DATA = 2'd3;

  typedef struct packed {
    logic wrIntEn;
    logic wrBufAddr;
    logic wrArg;
    logic wrCmd;
    logic wrBlkLen;
    logic wrBlkCnt;
    logic capLong;
    logic capShort;
  } hostStrobe_t;

endpackage

// File: rtl/sdhost_ctrl.sv
module sdhost_ctrl
  import sdhost_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [STAT_W-1:0] busWrLow,
  input  logic              cmdReady,
  input  logic              cmdDone,
  input  logic              dataDone,
  input  logic              cardInserted,
  input  logic              cardWriteProt,
  input  logic [1:0]        respType,
  input  logic [1:0]        cmdClass,
  input  logic [STAT_W-1:0] intEn,
  output hostStrobe_t       strb,
  output logic              cmdValid,
  output logic [STAT_W-1:0] statusQ,
  output logic [1:0]        cardState,
  output logic              irq
);

  logic awaitDone;
  logic pending;
  logic cmdWrite;
  logic cmdReject;
  logic [STAT_W-1:0] statusSet;
  logic [STAT_W-1:0] statusClr;
  logic [SYNC_STAGES-1:0] insSync;
  logic [SYNC_STAGES-1:0] wpSync;
  logic insPrev;
  logic insChange;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  assign pending   = cmdValid | awaitDone;
  assign cmdWrite  = busWrEn && hit(busAddr, OFF_CMD);
  assign cmdReject = cmdWrite && pending;

  always_comb begin
    strb           = '0;
    strb.wrIntEn   = busWrEn && hit(busAddr, OFF_INTEN);
    strb.wrBufAddr = busWrEn && hit(busAddr, OFF_BUF);
    strb.wrArg     = busWrEn && hit(busAddr, OFF_ARG);
    strb.wrCmd     = cmdWrite && !pending;
    strb.wrBlkLen  = busWrEn && hit(busAddr, OFF_BLKLEN);
    strb.wrBlkCnt  = busWrEn && hit(busAddr, OFF_BLKCNT);
    strb.capLong   = cmdDone && (respType == RESP_LONG);
    strb.capShort  = cmdDone && ((respType == RESP_SHORT) || (respType == RESP_OCR));
  end

  // request handshake and pending tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid  <= 1'b0;
      awaitDone <= 1'b0;
    end else begin
      if (strb.wrCmd)
        cmdValid <= 1'b1;
      else if (cmdValid && cmdReady)
        cmdValid <= 1'b0;

      if (cmdValid && cmdReady)
        awaitDone <= 1'b1;
      else if (cmdDone)
        awaitDone <= 1'b0;
    end
  end

  // card level synchronizers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      insSync <= '0;
      wpSync  <= '0;
      insPrev <= 1'b0;
    end else begin
      insSync <= {insSync[SYNC_STAGES-2:0], cardInserted};
      wpSync  <= {wpSync[SYNC_STAGES-2:0], cardWriteProt};
      insPrev <= insSync[SYNC_STAGES-1];
    end
  end

  assign insChange = insSync[SYNC_STAGES-1] ^ insPrev;
  assign cardState = {wpSync[SYNC_STAGES-1], insSync[SYNC_STAGES-1]};

  // status: set has priority over write-one-to-clear
  always_comb begin
    statusSet              = '0;
    statusSet[ST_CMD_END]  = cmdDone;
    statusSet[ST_DATA_END] = dataDone && (cmdClass == CLASS_WITH_DATA);
    statusSet[ST_CARD_CHG] = insChange;
    statusSet[ST_CMD_ERR]  = cmdReject;
    statusClr = (busWrEn && hit(busAddr, OFF_STATUS)) ? busWrLow : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      statusQ <= '0;
    else
      statusQ <= (statusQ & ~statusClr) | statusSet;
  end

  assign irq = |(statusQ & intEn);

endmodule

// File: rtl/sdhost_data.sv
module sdhost_data
  import sdhost_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LEN_W  = 11,
  parameter int CMD_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  hostStrobe_t              strb,
  input  logic [31:0]              busWrData,
  input  logic                     busRdEn,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [32*RESP_WORDS-1:0] respIn,
  input  logic [STAT_W-1:0]        statusQ,
  input  logic [1:0]               cardState,
  output logic [STAT_W-1:0]        intEn,
  output logic [31:0]              bufAddr,
  output logic [31:0]              cmdArg,
  output logic [CMD_W-1:0]         cmdWord,
  output logic [LEN_W-1:0]         blkLen,
  output logic [LEN_W-1:0]         blkCnt,
  output logic [31:0]              busRdData
);

  logic [31:0] respWord [RESP_WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn   <= '0;
      bufAddr <= '0;
      cmdArg  <= '0;
      cmdWord <= '0;
      blkLen  <= '0;
      blkCnt  <= '0;
    end else begin
      if (strb.wrIntEn)   intEn   <= busWrData[STAT_W-1:0];
      if (strb.wrBufAddr) bufAddr <= busWrData;
      if (strb.wrArg)     cmdArg  <= busWrData;
      if (strb.wrCmd)     cmdWord <= busWrData[CMD_W-1:0];
      if (strb.wrBlkLen)  blkLen  <= busWrData[LEN_W-1:0];
      if (strb.wrBlkCnt)  blkCnt  <= busWrData[LEN_W-1:0];
    end
  end

  for (genvar i = 0; i < RESP_WORDS; i++) begin : g_resp
    always_ff @(posedge clk) begin
      if (!rstN)
        respWord[i] <= '0;
      else if (strb.capLong || (strb.capShort && i == 0))
        respWord[i] <= respIn[32*i +: 32];
    end
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      case (busAddr)
        ADDR_W'(OFF_STATUS): busRdData = 32'(statusQ);
        ADDR_W'(OFF_INTEN):  busRdData = 32'(intEn);
        ADDR_W'(OFF_BUF):    busRdData = bufAddr;
        ADDR_W'(OFF_CMD):    busRdData = 32'(cmdWord);
        ADDR_W'(OFF_ARG):    busRdData = cmdArg;
        ADDR_W'(OFF_BLKLEN): busRdData = 32'(blkLen);
        ADDR_W'(OFF_BLKCNT): busRdData = 32'(blkCnt);
        ADDR_W'(OFF_CARD):   busRdData = 32'(cardState);
        default: begin
          for (int i = 0; i < RESP_WORDS; i++)
            if (busAddr == ADDR_W'(OFF_RESP0 + 4 * i))
              busRdData = respWord[i];
        end
      endcase
    end
  end

endmodule

// File: rtl/sdhost_reg_front.sv
module sdhost_reg_front
  import sdhost_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int LEN_W       = 11,
  parameter int CMD_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busWrEn,
  input  logic                     busRdEn,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [31:0]              busWrData,
  output logic [31:0]              busRdData,
  output logic                     cmdValid,
  input  logic                     cmdReady,
  output logic [CMD_W-1:0]         cmdWord,
  output logic [31:0]              cmdArg,
  output logic [31:0]              bufAddr,
  output logic [LEN_W-1:0]         blkLen,
  output logic [LEN_W-1:0]         blkCnt,
  input  logic                     cmdDone,
  input  logic                     dataDone,
  input  logic [32*RESP_WORDS-1:0] respIn,
  input  logic                     cardInserted,
  input  logic                     cardWriteProt,
  output logic                     irq
);

  hostStrobe_t       strb;
  logic [STAT_W-1:0] statusVec;
  logic [STAT_W-1:0] intEnVec;
  logic [1:0]        cardState;

  sdhost_ctrl #(
    .ADDR_W(ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .busWrLow(busWrData[STAT_W-1:0]),
    .cmdReady(cmdReady),
    .cmdDone(cmdDone),
    .dataDone(dataDone),
    .cardInserted(cardInserted),
    .cardWriteProt(cardWriteProt),
    .respType(cmdWord[9:8]),
    .cmdClass(cmdWord[13:12]),
    .intEn(intEnVec),
    .strb(strb),
    .cmdValid(cmdValid),
    .statusQ(statusVec),
    .cardState(cardState),
    .irq(irq)
  );

  sdhost_data #(
    .ADDR_W(ADDR_W),
    .LEN_W(LEN_W),
    .CMD_W(CMD_W)
  ) u_data (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .busWrData(busWrData),
    .busRdEn(busRdEn),
    .busAddr(busAddr),
    .respIn(respIn),
    .statusQ(statusVec),
    .cardState(cardState),
    .intEn(intEnVec),
    .bufAddr(bufAddr),
    .cmdArg(cmdArg),
    .cmdWord(cmdWord),
    .blkLen(blkLen),
    .blkCnt(blkCnt),
    .busRdData(busRdData)
  );

endmodule

// File: rtl/sdhost_checker.sv
module sdhost_checker
  import sdhost_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CMD_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWrData,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [CMD_W-1:0]  cmdWord,
  input logic              cmdDone,
  input logic              dataDone,
  input logic [STAT_W-1:0] statusVec,
  input logic [STAT_W-1:0] intEnVec,
  input logic              irq
);

  // R3: request held steady until accepted
  p_hold_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdWord)));

  // R3: request only rises after a command register write
  p_launch_src_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdValid) |-> $past(busWrEn && busAddr == ADDR_W'(OFF_CMD)));

  // R10: second launch while waiting is dropped and flagged
  p_reject_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && busWrEn && busAddr == ADDR_W'(OFF_CMD))
      |=> ($stable(cmdWord) && statusVec[ST_CMD_ERR]));

  // R6: no data event outside the data class
  p_no_data_evt_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataDone && cmdWord[13:12] != CLASS_WITH_DATA && !statusVec[ST_DATA_END])
      |=> !statusVec[ST_DATA_END]);

  // R8: clear without a coinciding event empties the bit
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFF_STATUS) && busWrData[ST_CMD_END] && !cmdDone)
      |=> !statusVec[ST_CMD_END]);

  // R9: fully masked status never interrupts
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (intEnVec == '0) |-> !irq);

endmodule

bind sdhost_reg_front sdhost_checker #(
  .ADDR_W(ADDR_W),
  .CMD_W(CMD_W)
) u_sdhost_checker (
  .clk(clk),
  .rstN(rstN),
  .busWrEn(busWrEn),
  .busAddr(busAddr),
  .busWrData(busWrData),
  .cmdValid(cmdValid),
  .cmdReady(cmdReady),
  .cmdWord(cmdWord),
  .cmdDone(cmdDone),
  .dataDone(dataDone),
  .statusVec(statusVec),
  .intEnVec(intEnVec),
  .irq(irq)
);

// File: tb/test_sdhost_reg_front.sv
`timescale 1ns/1ps
module test_sdhost_reg_front;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWrEn = 1'b0;
  logic         busRdEn = 1'b0;
  logic [5:0]   busAddr = '0;
  logic [31:0]  busWrData = '0;
  logic [31:0]  busRdData;
  logic         cmdValid;
  logic         cmdReady = 1'b0;
  logic [15:0]  cmdWord;
  logic [31:0]  cmdArg;
  logic [31:0]  bufAddr;
  logic [10:0]  blkLen;
  logic [10:0]  blkCnt;
  logic         cmdDone = 1'b0;
  logic         dataDone = 1'b0;
  logic [127:0] respIn = '0;
  logic         cardInserted = 1'b0;
  logic         cardWriteProt = 1'b0;
  logic         irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #10 clk = ~clk;

  sdhost_reg_front i_sdhost_reg_front (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWord(cmdWord),
    .cmdArg(cmdArg), .bufAddr(bufAddr), .blkLen(blkLen), .blkCnt(blkCnt),
    .cmdDone(cmdDone), .dataDone(dataDone), .respIn(respIn),
    .cardInserted(cardInserted), .cardWriteProt(cardWriteProt), .irq(irq)
  );

  // monitor: compare each read against the queued expectation
  always @(negedge clk) begin
    if (busRdEn) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (busRdData !== e) begin
        errors++;
        $display("FAIL %s: read 0x%08h expected 0x%08h", t, busRdData, e);
      end
    end
  end

  task automatic expectRead(input logic [5:0] a, input logic [31:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    @(posedge clk); #1;
    busRdEn = 1'b1; busAddr = a;
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic checkVal(input logic [31:0] act, input logic [31:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", t, act, e);
    end
  endtask

  task automatic acceptCmd();
    @(posedge clk); #1; cmdReady = 1'b1;
    @(posedge clk); #1; cmdReady = 1'b0;
  endtask

  task automatic finishCmd(input logic [127:0] r);
    @(posedge clk); #1; cmdDone = 1'b1; respIn = r;
    @(posedge clk); #1; cmdDone = 1'b0; respIn = '0;
  endtask

  task automatic finishData();
    @(posedge clk); #1; dataDone = 1'b1;
    @(posedge clk); #1; dataDone = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    checkVal(32'(irq), 0, "R1 irq");
    checkVal(32'(cmdValid), 0, "R1 cmdValid");
    expectRead(6'h00, 0, "R1 status");
    expectRead(6'h04, 0, "R1 mask");
    expectRead(6'h0C, 0, "R1 command");
    expectRead(6'h14, 0, "R1 resp0");

    // R2 register programming and readback
    regWrite(6'h08, 32'h8000_1000);
    regWrite(6'h10, 32'h0000_2A5C);
    regWrite(6'h24, 32'hFFFF_FFFF);
    regWrite(6'h28, 32'h0000_0005);
    expectRead(6'h08, 32'h8000_1000, "R2 buffer");
    expectRead(6'h10, 32'h0000_2A5C, "R2 argument");
    expectRead(6'h24, 32'h0000_07FF, "R2 block length 11 bits");
    expectRead(6'h28, 32'h0000_0005, "R2 block count");
    checkVal(32'(blkLen), 32'h7FF, "R3 blkLen port");
    checkVal(32'(blkCnt), 32'h5, "R3 blkCnt port");
    checkVal(bufAddr, 32'h8000_1000, "R3 bufAddr port");

    // R3 launch: opcode 17, short resp, data class, read
    regWrite(6'h0C, 32'h0000_B111);
    checkVal(32'(cmdValid), 1, "R3 valid after write");
    checkVal(32'(cmdWord), 32'hB111, "R3 cmdWord port");
    checkVal(cmdArg, 32'h0000_2A5C, "R3 cmdArg port");
    repeat (2) @(posedge clk);
    #1 checkVal(32'(cmdValid), 1, "R3 valid held without ready");

    // R10 second launch while pending
    regWrite(6'h0C, 32'h0000_0005);
    expectRead(6'h0C, 32'h0000_B111, "R10 command kept");
    expectRead(6'h00, 32'h8, "R10 error bit");
    acceptCmd();
    checkVal(32'(cmdValid), 0, "R3 valid drops after ready");

    // R4 short response, R5 end of command, R9 latch while masked
    finishCmd({32'h3333_3333, 32'h2222_2222, 32'h1111_1111, 32'h1111_0000});
    expectRead(6'h14, 32'h1111_0000, "R4 short word0");
    expectRead(6'h18, 0, "R4 short word1 untouched");
    expectRead(6'h20, 0, "R4 short word3 untouched");
    expectRead(6'h00, 32'h9, "R5 end of command");
    checkVal(32'(irq), 0, "R9 masked no irq");

    // R6 data end under data class
    finishData();
    expectRead(6'h00, 32'hB, "R6 data end with data class");

    // R9 mask and R8 clear
    regWrite(6'h04, 32'h1);
    checkVal(32'(irq), 1, "R9 irq with bit0 enabled");
    regWrite(6'h00, 32'h1);
    expectRead(6'h00, 32'hA, "R8 clear bit0 only");
    checkVal(32'(irq), 0, "R9 irq after clear");
    regWrite(6'h04, 32'hF);
    checkVal(32'(irq), 1, "R9 irq with full mask");
    regWrite(6'h00, 32'hA);
    expectRead(6'h00, 0, "R8 status empty");
    checkVal(32'(irq), 0, "R9 irq low when empty");
    regWrite(6'h04, 32'h0);

    // R4 long response into four words, R6 non-data class
    regWrite(6'h0C, 32'h0000_1202);
    acceptCmd();
    finishCmd({32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000});
    expectRead(6'h14, 32'hAAAA_0000, "R4 long word0");
    expectRead(6'h18, 32'hBBBB_0001, "R4 long word1");
    expectRead(6'h1C, 32'hCCCC_0002, "R4 long word2");
    expectRead(6'h20, 32'hDDDD_0003, "R4 long word3");
    finishData();
    expectRead(6'h00, 32'h1, "R6 data end ignored for other class");
    regWrite(6'h00, 32'h1);

    // R4 no response type, R8 event beats coinciding clear
    regWrite(6'h0C, 32'h0000_0000);
    acceptCmd();
    @(posedge clk); #1;
    cmdDone = 1'b1; respIn = {4{32'h5A5A_5A5A}};
    busWrEn = 1'b1; busAddr = 6'h00; busWrData = 32'h1;
    @(posedge clk); #1;
    cmdDone = 1'b0; respIn = '0; busWrEn = 1'b0;
    expectRead(6'h00, 32'h1, "R8 set wins over clear");
    expectRead(6'h14, 32'hAAAA_0000, "R4 none keeps word0");
    expectRead(6'h20, 32'hDDDD_0003, "R4 none keeps word3");
    regWrite(6'h00, 32'h1);

    // R7 card insertion and write protect
    cardInserted = 1'b1;
    repeat (5) @(posedge clk);
    expectRead(6'h00, 32'h4, "R7 rising insert event");
    expectRead(6'h2C, 32'h1, "R7 card state inserted");
    regWrite(6'h00, 32'h4);
    cardWriteProt = 1'b1;
    repeat (5) @(posedge clk);
    expectRead(6'h2C, 32'h3, "R7 card state protected");
    expectRead(6'h00, 32'h0, "R7 protect raises no event");
    cardInserted = 1'b0;
    repeat (5) @(posedge clk);
    expectRead(6'h00, 32'h4, "R7 falling insert event");
    expectRead(6'h2C, 32'h2, "R7 card state removed");

    // R11 unmapped and read-only
    expectRead(6'h30, 0, "R11 unmapped read");
    regWrite(6'h14, 32'hFFFF_FFFF);
    regWrite(6'h2C, 32'hFFFF_FFFF);
    expectRead(6'h14, 32'hAAAA_0000, "R11 resp word not writable");
    expectRead(6'h2C, 32'h2, "R11 card state not writable");

    repeat (2) @(posedge clk);
    summary();
  end

endmodule